// File: doc/BRIEF.md
# Route Cache with Idle Aging

This block is a small fully associative cache that sits in front of a slow next-hop lookup engine. A requester presents a destination address with a valid/ready handshake. When a valid entry holds that address, the cached next-hop identifier comes back one cycle later with a hit flag. This is the fast path.

When no entry holds the address, only the address is sent out on a slow-path request port. The requester is stalled until the slow engine answers. The answer is then returned to the requester and written into the cache. Only one miss is outstanding at any time. Entries are filled only from slow-path answers.

Each entry counts the periodic age ticks since its last use. An entry is dropped once that count passes a programmable idle limit. When every entry is in use, a new fill replaces the least recently used entry. A flush input empties the whole cache in one cycle.

Top module: `route_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `slow_req_valid` is 0, and every entry is invalid, so the first lookup of any address misses.
- R2: A request accepted (`req_valid` and `req_ready` both 1 at a rising edge) whose address matches a valid entry gives, in the next cycle, `rsp_valid`=1, `rsp_hit`=1 and `rsp_hop` equal to the stored next hop. `slow_req_valid` stays 0 and `req_ready` stays 1.
- R3: An accepted request that matches no valid entry gives, in the next cycle, `slow_req_valid`=1, `slow_req_addr` equal to the requested address, and `rsp_valid`=0. Nothing but the address goes out on the slow-path port.
- R4: `slow_rsp_valid`=1 in a cycle where `slow_req_valid` is 1 gives, in the next cycle, `rsp_valid`=1, `rsp_hit`=0, `rsp_hop` equal to `slow_rsp_hop`, `req_ready`=1 and `slow_req_valid`=0. The address is installed with an idle count of 0, and no address is ever held by two entries.
- R5: `req_ready` is 0 from the cycle after a miss is accepted until the cycle after the slow-path reply. A request held during that time is not accepted and does not change `slow_req_addr`.
- R6: Each cycle with `age_tick`=1 adds one to the idle count of every valid entry not used in that cycle. An entry whose count already equals or exceeds `idle_limit` at such a tick is invalidated instead. With limit L, an entry survives L ticks after its last use and is removed by tick L+1.
- R7: A hit in the same cycle as `age_tick` resets that entry's idle count to 0 and keeps the entry valid, even when its count had reached the limit.
- R8: A slow-path reply is installed into the lowest-numbered invalid entry. When all entries are valid, it replaces the entry whose last hit or install is the oldest.
- R9: `flush`=1 invalidates every entry at the next edge. A slow-path reply taken in a flush cycle is still returned on `rsp_*`, but it is not installed.
- R10: `slow_rsp_valid`=1 while no miss is outstanding is ignored. No response follows and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Cache can accept a request |
| req_addr | input | ADDR_W | Destination address to look up |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_hop | output | HOP_W | Next-hop identifier of the response |
| slow_req_valid | output | 1 | Miss outstanding toward the slow engine |
| slow_req_addr | output | ADDR_W | Address of the outstanding miss |
| slow_rsp_valid | input | 1 | Slow engine answer present |
| slow_rsp_hop | input | HOP_W | Next hop from the slow engine |
| age_tick | input | 1 | Periodic idle-aging pulse |
| idle_limit | input | IDLE_W | Idle ticks an entry may survive |
| flush | input | 1 | Invalidate all entries |

## Verification
A wrong valid bit, tag or idle count shows at the ports as a hit/miss mismatch on the next lookup of that address. A hit then carries no slow-path request; a miss raises `slow_req_valid` one cycle after acceptance. A wrong least-recently-used order shows only once the cache is full: the next fill evicts the wrong address, which later misses where a hit was due. A wrong control state shows within one cycle as a `req_ready` or `rsp_valid` that disagrees with the outstanding-miss status.

// File: rtl/route_cache_pkg.sv
package route_cache_pkg;

  typedef enum logic {
    RC_IDLE = 1'b0,
    RC_WAIT = 1'b1
  } rc_state_e;

endpackage

// File: rtl/rc_entry.sv
module rc_entry #(
  parameter int ADDR_W = 32,
  parameter int HOP_W  = 8,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              tick_i,
  input  logic              touch_i,
  input  logic              load_i,
  input  logic [IDLE_W-1:0] idle_limit_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [HOP_W-1:0]  ld_hop_i,
  output logic              valid_o,
  output logic              match_o,
  output logic [HOP_W-1:0]  hop_o
);

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] tag_q;
  logic [HOP_W-1:0]  hop_q;
  logic [IDLE_W-1:0] idle_q, idle_d;
  logic              idle_en;
  logic              expire;

  assign expire = tick_i && valid_q && (idle_q >= idle_limit_i);

  always_comb begin
    valid_d = valid_q;
    if (flush_i) begin
      valid_d = 1'b0;
    end else if (load_i || touch_i) begin
      valid_d = 1'b1;
    end else if (expire) begin
      valid_d = 1'b0;
    end
  end

  always_comb begin
    idle_en = load_i || touch_i || (tick_i && valid_q && !expire);
    idle_d  = (load_i || touch_i) ? '0 : idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idle_q  <= '0;
      tag_q   <= '0;
      hop_q   <= '0;
    end else begin
      valid_q <= valid_d;
      if (idle_en) begin
        idle_q <= idle_d;
      end
      if (load_i) begin
        tag_q <= ld_addr_i;
        hop_q <= ld_hop_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign match_o = valid_q && (tag_q == lk_addr_i);
  assign hop_o   = hop_q;

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !valid_o); // R9
  AST_LOAD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && !flush_i |=> valid_o && (idle_q == '0)); // R4
  AST_TOUCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i && !flush_i |=> valid_o && (idle_q == '0)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !touch_i && !load_i && !flush_i |=> $stable(idle_q) && $stable(valid_o)); // R6

endmodule

// File: rtl/rc_lru.sv
module rc_lru #(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] lru_idx_o
);

  // rank 0 = most recent, ENTRIES-1 = least recent
  logic [ENTRIES-1:0][IDX_W-1:0] rank_q, rank_d;
  logic [ENTRIES-1:0]            oldest;
  logic [IDX_W-1:0]              touched_rank;

  assign touched_rank = rank_q[touch_idx_i];

  always_comb begin
    rank_d = rank_q;
    if (touch_i) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (touch_idx_i == IDX_W'(i)) begin
          rank_d[i] = '0;
        end else if (rank_q[i] < touched_rank) begin
          rank_d[i] = rank_q[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        rank_q[i] <= IDX_W'(i);
      end
    end else if (touch_i) begin
      rank_q <= rank_d;
    end
  end

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
      assign oldest[g] = (rank_q[g] == IDX_W'(ENTRIES - 1));
    end
  endgenerate

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (oldest[i]) begin
        lru_idx_o = IDX_W'(i);
      end
    end
  end

  AST_LRU_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest)); // R8
  AST_TOUCH_LEAVES_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> (lru_idx_o != $past(touch_idx_i))); // R8

endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
  import route_cache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int HOP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              hit_i,
  input  logic [HOP_W-1:0]  hit_hop_i,
  input  logic              slow_rsp_valid_i,
  input  logic [HOP_W-1:0]  slow_rsp_hop_i,
  output logic              req_ready_o,
  output logic              accept_o,
  output logic              reply_take_o,
  output logic              slow_req_valid_o,
  output logic [ADDR_W-1:0] slow_req_addr_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [HOP_W-1:0]  rsp_hop_o
);

  rc_state_e         state_q, state_d;
  logic [ADDR_W-1:0] pend_q;
  logic              pend_en;
  logic              rsp_valid_q, rsp_valid_d;
  logic              rsp_hit_q, rsp_hit_d;
  logic [HOP_W-1:0]  rsp_hop_q, rsp_hop_d;

  assign req_ready_o      = (state_q == RC_IDLE);
  assign accept_o         = req_valid_i && req_ready_o;
  assign reply_take_o     = (state_q == RC_WAIT) && slow_rsp_valid_i;
  assign slow_req_valid_o = (state_q == RC_WAIT);
  assign slow_req_addr_o  = pend_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      RC_IDLE: if (accept_o && !hit_i) state_d = RC_WAIT;
      RC_WAIT: if (slow_rsp_valid_i)   state_d = RC_IDLE;
      default: state_d = RC_IDLE;
    endcase
  end

  always_comb begin
    pend_en     = accept_o && !hit_i;
    rsp_hit_d   = accept_o && hit_i;
    rsp_valid_d = rsp_hit_d || reply_take_o;
    rsp_hop_d   = rsp_hit_d ? hit_hop_i : slow_rsp_hop_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= RC_IDLE;
      pend_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_hop_q   <= '0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_hit_q   <= rsp_hit_d;
      if (pend_en) begin
        pend_q <= req_addr_i;
      end
      if (rsp_valid_d) begin
        rsp_hop_q <= rsp_hop_d;
      end
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_hop_o   = rsp_hop_q;

  AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && hit_i |=> rsp_valid_o && rsp_hit_o && (rsp_hop_o == $past(hit_hop_i)) && req_ready_o); // R2
  AST_MISS_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && !hit_i |=> slow_req_valid_o && !req_ready_o && !rsp_valid_o
                           && (slow_req_addr_o == $past(req_addr_i))); // R3
  AST_REPLY_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    reply_take_o |=> rsp_valid_o && !rsp_hit_o && req_ready_o && !slow_req_valid_o
                     && (rsp_hop_o == $past(slow_rsp_hop_i))); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    slow_req_valid_o && !slow_rsp_valid_i |=> slow_req_valid_o && !req_ready_o
                                              && $stable(slow_req_addr_o)); // R5
  AST_STRAY_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_req_valid_o && !accept_o |=> !rsp_valid_o); // R10

endmodule

// File: rtl/route_cache.sv
module route_cache #(
  parameter int ADDR_W  = 32,
  parameter int HOP_W   = 8,
  parameter int ENTRIES = 4,
  parameter int IDLE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [HOP_W-1:0]  rsp_hop,
  output logic              slow_req_valid,
  output logic [ADDR_W-1:0] slow_req_addr,
  input  logic              slow_rsp_valid,
  input  logic [HOP_W-1:0]  slow_rsp_hop,
  input  logic              age_tick,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              flush
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] load_vec;
  logic [ENTRIES-1:0] touch_vec;
  logic [HOP_W-1:0]   hop_arr [ENTRIES];

  logic               hit_any;
  logic [IDX_W-1:0]   hit_idx;
  logic [HOP_W-1:0]   hit_hop;
  logic               free_any;
  logic [IDX_W-1:0]   free_idx;
  logic [IDX_W-1:0]   lru_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic               accept;
  logic               reply_take;
  logic               lru_touch;
  logic [IDX_W-1:0]   lru_touch_idx;

  assign hit_any = |match_vec;

  always_comb begin
    hit_idx = '0;
    hit_hop = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) begin
        hit_idx = IDX_W'(i);
        hit_hop = hop_arr[i];
      end
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
      end
    end
  end

  assign free_any      = !(&valid_vec);
  assign victim_idx    = free_any ? free_idx : lru_idx;
  assign lru_touch     = (accept && hit_any) || reply_take;
  assign lru_touch_idx = reply_take ? victim_idx : hit_idx;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign load_vec[g]  = reply_take && (victim_idx == IDX_W'(g));
      assign touch_vec[g] = accept && match_vec[g];

      rc_entry #(
        .ADDR_W (ADDR_W),
        .HOP_W  (HOP_W),
        .IDLE_W (IDLE_W)
      ) u_entry (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .tick_i       (age_tick),
        .touch_i      (touch_vec[g]),
        .load_i       (load_vec[g]),
        .idle_limit_i (idle_limit),
        .lk_addr_i    (req_addr),
        .ld_addr_i    (slow_req_addr),
        .ld_hop_i     (slow_rsp_hop),
        .valid_o      (valid_vec[g]),
        .match_o      (match_vec[g]),
        .hop_o        (hop_arr[g])
      );
    end
  endgenerate

  rc_lru #(
    .ENTRIES (ENTRIES)
  ) u_lru (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_i     (lru_touch),
    .touch_idx_i (lru_touch_idx),
    .lru_idx_o   (lru_idx)
  );

  rc_ctrl #(
    .ADDR_W (ADDR_W),
    .HOP_W  (HOP_W)
  ) u_ctrl (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid_i      (req_valid),
    .req_addr_i       (req_addr),
    .hit_i            (hit_any),
    .hit_hop_i        (hit_hop),
    .slow_rsp_valid_i (slow_rsp_valid),
    .slow_rsp_hop_i   (slow_rsp_hop),
    .req_ready_o      (req_ready),
    .accept_o         (accept),
    .reply_take_o     (reply_take),
    .slow_req_valid_o (slow_req_valid),
    .slow_req_addr_o  (slow_req_addr),
    .rsp_valid_o      (rsp_valid),
    .rsp_hit_o        (rsp_hit),
    .rsp_hop_o        (rsp_hop)
  );

  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec)); // R4
  AST_SINGLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec)); // R8
  AST_FILL_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    reply_take && free_any && !flush |=> valid_vec[$past(free_idx)]); // R8

endmodule

// File: tb/route_cache_tb_top.sv
`timescale 1ns/1ps
module route_cache_tb_top;

  localparam int AW = 32;
  localparam int HW = 8;
  localparam int N  = 4;
  localparam int IW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready;
  logic [AW-1:0] req_addr;
  logic          rsp_valid, rsp_hit;
  logic [HW-1:0] rsp_hop;
  logic          slow_req_valid;
  logic [AW-1:0] slow_req_addr;
  logic          slow_rsp_valid;
  logic [HW-1:0] slow_rsp_hop;
  logic          age_tick;
  logic [IW-1:0] idle_limit;
  logic          flush;

  always #2.5 clk = ~clk;

  route_cache #(.ADDR_W(AW), .HOP_W(HW), .ENTRIES(N), .IDLE_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hop(rsp_hop),
    .slow_req_valid(slow_req_valid), .slow_req_addr(slow_req_addr),
    .slow_rsp_valid(slow_rsp_valid), .slow_rsp_hop(slow_rsp_hop),
    .age_tick(age_tick), .idle_limit(idle_limit), .flush(flush)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int lim   = 200;

  bit            m_valid [N];
  logic [AW-1:0] m_tag   [N];
  logic [HW-1:0] m_hop   [N];
  int            m_idle  [N];
  int            m_use   [N];
  int            use_ctr = 0;

  logic [AW-1:0] pool [6];

  assign idle_limit = IW'(lim);

  function automatic logic [HW-1:0] hopf(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int v = 0;
    for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) v = i;
    if (m_valid[v]) begin
      for (int i = 0; i < N; i++) if (m_use[i] < m_use[v]) v = i;
    end
    return v;
  endfunction

  task automatic model_edge(input bit tk, input bit fl, input int touch, input int inst,
                            input logic [AW-1:0] a, input logic [HW-1:0] h);
    for (int i = 0; i < N; i++) begin
      if (fl) begin
        m_valid[i] = 1'b0;
      end else if (i == inst) begin
        m_valid[i] = 1'b1; m_tag[i] = a; m_hop[i] = h; m_idle[i] = 0;
        use_ctr++; m_use[i] = use_ctr;
      end else if (i == touch) begin
        m_idle[i] = 0; use_ctr++; m_use[i] = use_ctr;
      end else if (tk && m_valid[i]) begin
        if (m_idle[i] >= lim) m_valid[i] = 1'b0;
        else m_idle[i]++;
      end
    end
  endtask

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic lookup(input string rq, input logic [AW-1:0] a, input bit tk, input bit fl_reply);
    int idx;
    int v;
    int w;
    bit t2;
    logic [HW-1:0] eh;
    @(negedge clk);
    chk("R5", "req_ready before request", 32'(req_ready), 32'd1);
    idx = m_find(a);
    eh  = (idx >= 0) ? m_hop[idx] : hopf(a);
    req_valid = 1'b1; req_addr = a; age_tick = tk;
    @(posedge clk);
    model_edge(tk, 1'b0, idx, -1, a, '0);
    @(negedge clk);
    req_valid = 1'b0; age_tick = 1'b0;
    chk(rq, "rsp_hit/hit expected", 32'(rsp_valid && rsp_hit), 32'(idx >= 0));
    if (idx >= 0) begin
      chk("R2", "rsp_valid on hit", 32'(rsp_valid), 32'd1);
      chk("R2", "rsp_hop on hit", 32'(rsp_hop), 32'(eh));
      chk("R2", "slow_req_valid on hit", 32'(slow_req_valid), 32'd0);
    end else begin
      chk("R3", "rsp_valid on miss", 32'(rsp_valid), 32'd0);
      chk("R3", "slow_req_valid on miss", 32'(slow_req_valid), 32'd1);
      chk("R3", "slow_req_addr", slow_req_addr, a);
      chk("R5", "req_ready during miss", 32'(req_ready), 32'd0);
      w = $urandom_range(0, 3);
      for (int k = 0; k < w; k++) begin
        t2 = ($urandom_range(0, 2) == 0);
        age_tick = t2; req_valid = 1'b1; req_addr = a ^ 32'h0000_0100;
        @(posedge clk);
        model_edge(t2, 1'b0, -1, -1, a, '0);
        @(negedge clk);
        age_tick = 1'b0;
        chk("R5", "req_ready while stalled", 32'(req_ready), 32'd0);
        chk("R5", "rsp_valid while stalled", 32'(rsp_valid), 32'd0);
        chk("R5", "slow_req_addr held", slow_req_addr, a);
      end
      req_valid = 1'b0;
      t2 = ($urandom_range(0, 2) == 0);
      age_tick = t2; flush = fl_reply; slow_rsp_valid = 1'b1; slow_rsp_hop = eh;
      v = m_victim();
      @(posedge clk);
      model_edge(t2, fl_reply, -1, v, a, eh);
      @(negedge clk);
      slow_rsp_valid = 1'b0; flush = 1'b0; age_tick = 1'b0;
      chk("R4", "rsp_valid after reply", 32'(rsp_valid), 32'd1);
      chk("R4", "rsp_hit after reply", 32'(rsp_hit), 32'd0);
      chk("R4", "rsp_hop after reply", 32'(rsp_hop), 32'(eh));
      chk("R4", "req_ready after reply", 32'(req_ready), 32'd1);
      chk("R4", "slow_req_valid after reply", 32'(slow_req_valid), 32'd0);
    end
  endtask

  task automatic idle_cyc(input bit tk, input bit fl, input bit stray);
    @(negedge clk);
    age_tick = tk; flush = fl; slow_rsp_valid = stray; slow_rsp_hop = 8'hEE;
    @(posedge clk);
    model_edge(tk, fl, -1, -1, '0, '0);
    @(negedge clk);
    age_tick = 1'b0; flush = 1'b0; slow_rsp_valid = 1'b0;
    if (stray) chk("R10", "rsp_valid after stray reply", 32'(rsp_valid), 32'd0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int r;
    void'($urandom(32'd917));
    pool[0] = 32'h0A00_0001; pool[1] = 32'h0A00_0102; pool[2] = 32'hC0A8_0203;
    pool[3] = 32'hC0A8_0304; pool[4] = 32'h1000_0405; pool[5] = 32'h1000_0506;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_hop[i] = '0; m_idle[i] = 0; m_use[i] = 0;
    end
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; slow_rsp_valid = 1'b0;
    slow_rsp_hop = '0; age_tick = 1'b0; flush = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready after reset", 32'(req_ready), 32'd1);
    chk("R1", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1", "slow_req_valid after reset", 32'(slow_req_valid), 32'd0);

    lookup("R1", pool[0], 1'b0, 1'b0);
    lookup("R2", pool[0], 1'b0, 1'b0);

    // R8: fill, refresh pool[0], then overflow evicts the oldest
    lookup("R8", pool[1], 1'b0, 1'b0);
    lookup("R8", pool[2], 1'b0, 1'b0);
    lookup("R8", pool[3], 1'b0, 1'b0);
    lookup("R8", pool[0], 1'b0, 1'b0);
    lookup("R8", pool[4], 1'b0, 1'b0);
    lookup("R8", pool[1], 1'b0, 1'b0);
    lookup("R8", pool[0], 1'b0, 1'b0);

    idle_cyc(1'b0, 1'b0, 1'b1);  // R10
    lookup("R10", pool[0], 1'b0, 1'b0);

    idle_cyc(1'b0, 1'b1, 1'b0);  // R9 flush
    lookup("R9", pool[0], 1'b0, 1'b1);
    lookup("R9", pool[0], 1'b0, 1'b0);
    lookup("R9", pool[0], 1'b0, 1'b0);

    idle_cyc(1'b0, 1'b1, 1'b0);  // R6 idle aging, limit 2
    lim = 2;
    lookup("R6", pool[2], 1'b0, 1'b0);
    idle_cyc(1'b1, 1'b0, 1'b0);
    idle_cyc(1'b1, 1'b0, 1'b0);
    lookup("R6", pool[2], 1'b0, 1'b0);
    repeat (3) idle_cyc(1'b1, 1'b0, 1'b0);
    lookup("R6", pool[2], 1'b0, 1'b0);

    lim = 1;                     // R7 hit together with tick
    lookup("R7", pool[3], 1'b0, 1'b0);
    idle_cyc(1'b1, 1'b0, 1'b0);
    lookup("R7", pool[3], 1'b1, 1'b0);
    idle_cyc(1'b1, 1'b0, 1'b0);
    lookup("R7", pool[3], 1'b0, 1'b0);

    lim = 3;
    for (int it = 0; it < 500; it++) begin
      r = $urandom_range(0, 99);
      if (r < 70) lookup("R8", pool[$urandom_range(0, 5)], ($urandom_range(0, 3) == 0),
                         ($urandom_range(0, 19) == 0));
      else if (r < 88) idle_cyc(1'b1, 1'b0, 1'b0);
      else if (r < 92) idle_cyc(1'b0, 1'b1, 1'b0);
      else if (r < 95) idle_cyc(1'b0, 1'b0, 1'b1);
      else lim = $urandom_range(1, 6);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule